// File: doc/BRIEF.md
# Asynchronous Memory Write Timing Engine

This block performs a single asynchronous write to an external memory or peripheral whose address and data buses are separate. An internal functional clock drives it. When the engine is idle and sees a request, it captures the byte address, the 16-bit write data, the active-low byte enables and a set of timing values. It then counts functional clock cycles from the start of the access.

Chip select, address valid and write enable are all active low. Each has its own programmed assert count and release count. The total access length is programmed separately. Address, data and byte enables appear on the external pins at the start of the access and stay there until the access ends. They also keep their values between accesses. The direction output reads "out" for the whole access. When the access ends, a one-cycle done pulse is raised.

Top module: `async_wr_engine`

## Requirements
- R1: While reset is active and in the first cycle after it is released, all three strobes are high, `mem_dir_out` is 0, `wr_done` is 0, and the address, data and byte-enable pins are 0.
- R2: A request sampled high on a clock edge while idle starts an access. The access runs in the cycles that follow, with the cycle count at 0 in the first of them. During the access, `mem_addr` equals `wr_addr[AW-1:1]` as captured at that edge. `mem_data` and `mem_be_n` equal the captured data and byte enables. None of these pins change until the access ends.
- R3: During an access, `mem_cs_n` is 0 exactly in the cycles whose count c satisfies `cs_on <= c < cs_off`. Both timing values are captured at the start edge.
- R4: During an access, `mem_adv_n` is 0 exactly when `adv_on <= c < adv_off`.
- R5: During an access, `mem_we_n` is 0 exactly when `we_on <= c < we_off`.
- R6: An access lasts max(`cyc_len`, 1) cycles, and `mem_dir_out` is 1 for all of them. `wr_done` is 1 for exactly one cycle: the first idle cycle after the access.
- R7: Whenever no access is running, all three strobes are high. This holds even when a release count is larger than the access length.
- R8: A request raised while an access runs is ignored. Pins and timing keep following the running access.
- R9: While idle, `mem_addr`, `mem_data` and `mem_be_n` keep the values of the last access.
- R10: A strobe whose assert count is not lower than its release count stays high for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request, sampled while idle |
| wr_addr | input | AW | Byte address |
| wr_data | input | DW | Write data |
| wr_be_n | input | DW/8 | Active-low byte enables |
| cs_on | input | 4 | Chip-select assert count |
| cs_off | input | 5 | Chip-select release count |
| adv_on | input | 4 | Address-valid assert count |
| adv_off | input | 5 | Address-valid release count |
| we_on | input | 4 | Write-enable assert count |
| we_off | input | 5 | Write-enable release count |
| cyc_len | input | 5 | Access length in cycles |
| mem_addr | output | AW-1 | External word address |
| mem_data | output | DW | External data bus |
| mem_be_n | output | DW/8 | External byte enables |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dir_out | output | 1 | 1 = bus driven outward |
| wr_done | output | 1 | One-cycle end-of-access pulse |

## Verification
The assertions assume that `wr_req` and every timing and data input are stable across each rising edge, and that reset is held for at least one edge before it is released. The bench meets this by changing every input only on the falling edge. The bench also holds requests high across running accesses and across their ends. This exercises the ignore rule, and it exercises back-to-back starts in the first idle cycle. Timing values include zero length, release counts past the end and empty windows, which tests the edges of the counter comparison.

// File: rtl/awe_pkg.sv
package awe_pkg;
  localparam int ON_W  = 4;
  localparam int OFF_W = 5;
  localparam int NSTB  = 3;   // 0: chip select, 1: address valid, 2: write enable

  typedef struct packed {
    logic [ON_W-1:0]  on;
    logic [OFF_W-1:0] off;
  } win_t;

  // strobe active in count c when on <= c < off
  function automatic logic in_window(input logic [OFF_W-1:0] c, input win_t w);
    logic [OFF_W-1:0] on_ext;
    on_ext = {{(OFF_W-ON_W){1'b0}}, w.on};
    return (on_ext <= c) && (c < w.off);
  endfunction

  // effective length: a zero length counts as one cycle
  function automatic logic [OFF_W-1:0] eff_len(input logic [OFF_W-1:0] len);
    return (len == '0) ? OFF_W'(1) : len;
  endfunction

  function automatic logic is_last(input logic [OFF_W-1:0] c, input logic [OFF_W-1:0] len);
    return ({1'b0, c} + 1'b1) >= {1'b0, eff_len(len)};
  endfunction
endpackage

// File: rtl/awe_ctrl.sv
module awe_ctrl
  import awe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [OFF_W-1:0] len_in,
  output logic             busy,
  output logic             start,
  output logic [OFF_W-1:0] cnt,
  output logic [OFF_W-1:0] len_q,
  output logic             done
);
  logic last_beat;

  assign start     = req && !busy;
  assign last_beat = busy && is_last(cnt, len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      len_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= last_beat;
      if (start) begin
        busy  <= 1'b1;
        cnt   <= '0;
        len_q <= len_in;
      end else if (last_beat) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/awe_datapath.sv
module awe_datapath
  import awe_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  localparam int BEW = DW / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [AW-1:0]         addr_in,
  input  logic [DW-1:0]         data_in,
  input  logic [BEW-1:0]        be_n_in,
  input  win_t [NSTB-1:0]       win_in,
  output logic [AW-2:0]         addr_q,
  output logic [DW-1:0]         data_q,
  output logic [BEW-1:0]        be_n_q,
  output win_t [NSTB-1:0]       win_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      be_n_q <= '0;
      win_q  <= '0;
    end else if (start) begin
      addr_q <= addr_in[AW-1:1];
      data_q <= data_in;
      be_n_q <= be_n_in;
      win_q  <= win_in;
    end
  end
endmodule

// File: rtl/awe_strobes.sv
module awe_strobes
  import awe_pkg::*;
(
  input  logic             busy,
  input  logic [OFF_W-1:0] cnt,
  input  win_t [NSTB-1:0]  win,
  output logic [NSTB-1:0]  stb_n
);
  for (genvar i = 0; i < NSTB; i++) begin : g_stb
    assign stb_n[i] = !(busy && in_window(cnt, win[i]));
  end
endmodule

// File: rtl/async_wr_engine.sv
module async_wr_engine
  import awe_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [DW/8-1:0]   wr_be_n,
  input  logic [ON_W-1:0]   cs_on,
  input  logic [OFF_W-1:0]  cs_off,
  input  logic [ON_W-1:0]   adv_on,
  input  logic [OFF_W-1:0]  adv_off,
  input  logic [ON_W-1:0]   we_on,
  input  logic [OFF_W-1:0]  we_off,
  input  logic [OFF_W-1:0]  cyc_len,
  output logic [AW-2:0]     mem_addr,
  output logic [DW-1:0]     mem_data,
  output logic [DW/8-1:0]   mem_be_n,
  output logic              mem_cs_n,
  output logic              mem_adv_n,
  output logic              mem_we_n,
  output logic              mem_dir_out,
  output logic              wr_done
);
  logic             busy, start;
  logic [OFF_W-1:0] cnt, len_q;
  win_t [NSTB-1:0]  win_in, win_q;
  logic [NSTB-1:0]  stb_n;

  assign win_in[0] = '{on: cs_on,  off: cs_off};
  assign win_in[1] = '{on: adv_on, off: adv_off};
  assign win_in[2] = '{on: we_on,  off: we_off};

  awe_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(wr_req), .len_in(cyc_len),
    .busy(busy), .start(start), .cnt(cnt), .len_q(len_q), .done(wr_done)
  );

  awe_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .start(start),
    .addr_in(wr_addr), .data_in(wr_data), .be_n_in(wr_be_n), .win_in(win_in),
    .addr_q(mem_addr), .data_q(mem_data), .be_n_q(mem_be_n), .win_q(win_q)
  );

  awe_strobes u_stb (.busy(busy), .cnt(cnt), .win(win_q), .stb_n(stb_n));

  assign mem_cs_n    = stb_n[0];
  assign mem_adv_n   = stb_n[1];
  assign mem_we_n    = stb_n[2];
  assign mem_dir_out = busy;
endmodule

// File: rtl/awe_chk.sv
module awe_chk
  import awe_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_req,
  input logic [AW-2:0]     mem_addr,
  input logic [DW-1:0]     mem_data,
  input logic [DW/8-1:0]   mem_be_n,
  input logic              mem_cs_n,
  input logic              mem_adv_n,
  input logic              mem_we_n,
  input logic              mem_dir_out,
  input logic              wr_done,
  input logic              busy,
  input logic [OFF_W-1:0]  cnt,
  input logic [OFF_W-1:0]  len_q
);
  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_dir_out |-> (mem_cs_n && mem_adv_n && mem_we_n));

  assert_bus_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dir_out && $past(mem_dir_out)) |->
      ($stable(mem_addr) && $stable(mem_data) && $stable(mem_be_n)));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !mem_dir_out) |=> (mem_dir_out && cnt == '0));

  assert_idle_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_dir_out && !$past(mem_dir_out)) |->
      ($stable(mem_addr) && $stable(mem_data) && $stable(mem_be_n)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> !mem_dir_out);

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < eff_len(len_q)));
endmodule

bind async_wr_engine awe_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req),
  .mem_addr(mem_addr), .mem_data(mem_data), .mem_be_n(mem_be_n),
  .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_we_n(mem_we_n),
  .mem_dir_out(mem_dir_out), .wr_done(wr_done),
  .busy(busy), .cnt(cnt), .len_q(len_q)
);

// File: tb/sim_async_wr_engine.sv
module sim_async_wr_engine;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] wr_be_n = '0;
  logic [3:0] cs_on = '0, adv_on = '0, we_on = '0;
  logic [4:0] cs_off = '0, adv_off = '0, we_off = '0, cyc_len = '0;
  logic [AW-2:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic [1:0] mem_be_n;
  logic mem_cs_n, mem_adv_n, mem_we_n, mem_dir_out, wr_done;

  always #4 clk = ~clk;   // 125 MHz

  async_wr_engine #(.AW(AW), .DW(DW)) u0 (.*);

  int total = 0;
  int bad = 0;
  bit checking = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_busy = 0, m_done = 0, m_ign = 0;
  int m_cnt = 0, m_len = 0;
  int m_addr = 0, m_data = 0, m_be = 0;
  int m_on[3], m_off[3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_ign = 0; m_cnt = 0; m_len = 0;
      m_addr = 0; m_data = 0; m_be = 0;
      for (int i = 0; i < 3; i++) begin m_on[i] = 0; m_off[i] = 0; end
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (wr_req) m_ign = 1;
        if (m_cnt + 1 >= ((m_len == 0) ? 1 : m_len)) begin
          m_busy = 0; m_done = 1;
        end else m_cnt++;
      end else if (wr_req) begin
        m_busy = 1; m_cnt = 0; m_ign = 0; m_len = int'(cyc_len);
        m_addr = int'(wr_addr) / 2; m_data = int'(wr_data); m_be = int'(wr_be_n);
        m_on[0] = cs_on;  m_off[0] = cs_off;
        m_on[1] = adv_on; m_off[1] = adv_off;
        m_on[2] = we_on;  m_off[2] = we_off;
      end
    end
  end

  function automatic int exp_stb(int i);
    return (m_busy && m_on[i] <= m_cnt && m_cnt < m_off[i]) ? 0 : 1;
  endfunction

  function automatic string stb_tag(int i);
    if (!m_busy) return "R7";
    if (m_on[i] >= m_off[i]) return "R10";
    return (i == 0) ? "R3" : (i == 1) ? "R4" : "R5";
  endfunction

  always @(negedge clk) begin
    if (checking) begin
      string btag;
      chk(stb_tag(0), mem_cs_n,  exp_stb(0));
      chk(stb_tag(1), mem_adv_n, exp_stb(1));
      chk(stb_tag(2), mem_we_n,  exp_stb(2));
      chk("R6", mem_dir_out, m_busy);
      chk("R6", wr_done, m_done);
      btag = m_busy ? (m_ign ? "R8" : "R2") : "R9";
      chk(btag, mem_addr, m_addr);
      chk(btag, mem_data, m_data);
      chk(btag, mem_be_n, m_be);
    end
  end

  task automatic set_t(int cn, int cf, int an, int af, int wn, int wf, int cl);
    cs_on = 4'(cn); cs_off = 5'(cf); adv_on = 4'(an); adv_off = 5'(af);
    we_on = 4'(wn); we_off = 5'(wf); cyc_len = 5'(cl);
  endtask

  // raise the request for hold cycles, with new bus values each cycle
  task automatic issue(int hold);
    for (int k = 0; k < hold; k++) begin
      wr_req = 1'b1;
      wr_addr = AW'($urandom); wr_data = DW'($urandom); wr_be_n = 2'($urandom);
      @(negedge clk);
      if (k == 0) set_t($urandom_range(0, 15), $urandom_range(0, 31), $urandom_range(0, 15),
                        $urandom_range(0, 31), $urandom_range(0, 15), $urandom_range(0, 31),
                        $urandom_range(0, 31));
    end
    wr_req = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", mem_cs_n, 1); chk("R1", mem_adv_n, 1); chk("R1", mem_we_n, 1);
    chk("R1", mem_dir_out, 0); chk("R1", wr_done, 0); chk("R1", mem_addr, 0);
    chk("R1", mem_data, 0);
    checking = 1;
    // typical windows
    set_t(1, 10, 0, 3, 2, 8, 12);
    wr_req = 1; wr_addr = 12'hABC; wr_data = 16'h1234; wr_be_n = 2'b01;
    @(negedge clk); wr_req = 0;
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
    // zero length
    set_t(0, 5, 0, 5, 0, 5, 0);
    wr_req = 1; @(negedge clk); wr_req = 0; repeat (3) @(negedge clk);
    // release past the end of the access
    set_t(0, 31, 1, 31, 2, 31, 5);
    wr_req = 1; @(negedge clk); wr_req = 0;
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
    // empty windows (R10)
    set_t(5, 5, 9, 3, 15, 0, 10);
    wr_req = 1; @(negedge clk); wr_req = 0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
    // request held across accesses (R8, back-to-back)
    set_t(1, 4, 0, 2, 1, 3, 6);
    issue(20);
    for (int n = 0; n < 60; n++) issue($urandom_range(1, 8));
    checking = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule